// File: doc/BRIEF.md
# Prioritized Interrupt Vector Selector

This block looks at a set of interrupt slots and picks the one that should be serviced next. Each slot has a pending flag and an individual enable. It also has a fixed maskability class that decides how the enables apply. A global enable gates the fully maskable slots only. When a slot wins, the block raises a request to the processor. It shows the winning slot number and a 16-bit handler-table address, which is the table base plus twice the slot number. The highest slot number has the highest priority.

The topmost slot is the reset entry. It wins whenever its flag is set, whatever the enables and its class. When the processor takes the request, the block pulses a one-cycle clear line for the slot it served, so that a peripheral can drop a flag that has only one source. Slots shared by several sources get no clear pulse, and neither does the reset slot. Software polls and clears those flags itself.

Top module: `irq_vector_arbiter`

## Requirements
- R1: While a request is raised, `vector_o` equals `VEC_BASE` + 2 × `sel_o`. With defaults, slot 15 gives 16'hFFFE and slot 0 gives 16'hFFE0.
- R2: Among eligible slots, the one with the highest index is selected and shown on `sel_o`.
- R3: A slot of class non-maskable (class code 2'b10 or 2'b11 in `CLASS_MAP`) is eligible whenever its flag is set, regardless of `ie_i` and `gie_i`. With defaults, slot 14 is non-maskable.
- R4: A slot of class partly maskable (code 2'b01) is eligible only when its flag and its `ie_i` bit are both set, and `gie_i` has no effect on it. With defaults, slot 13 is partly maskable.
- R5: A slot of class maskable (code 2'b00) is eligible only when its flag, its `ie_i` bit and `gie_i` are all set. With defaults, slots 0 to 12 are maskable.
- R6: The top slot (index `N_SLOT`-1, the reset entry) is eligible whenever its flag is set, ignoring enables and its class code, so it overrides every other slot.
- R7: With no eligible slot, `irq_o` is 0, and `sel_o` and `vector_o` are 0.
- R8: When `take_i` is high at a clock edge while a request is raised for a single-source slot, `clr_o` shows a one-hot bit at that slot for exactly the next cycle.
- R9: No clear pulse is produced for a slot marked in `SHARED_MAP` (defaults: slots 2 and 14), for the top slot, or for `take_i` while no request is raised.
- R10: While `rst_n` is low and right after it, `clr_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flag_i | input | N_SLOT | Pending flag per slot |
| ie_i | input | N_SLOT | Individual enable per slot |
| gie_i | input | 1 | Global enable for maskable slots |
| take_i | input | 1 | Processor accepts the current request |
| irq_o | output | 1 | A slot is eligible |
| sel_o | output | SEL_W | Index of the winning slot |
| vector_o | output | ADDR_W | Handler-table address of the winner |
| clr_o | output | N_SLOT | One-cycle clear pulse for the served slot |

## Verification
The bench builds the block with its default parameters: sixteen slots, base 16'hFFE0, the top three slots non-maskable, non-maskable and partly maskable, and slots 2 and 14 shared. This one setup reaches all three classes, the reset override, and both the lowest and highest table addresses. It also covers shared and single-source slots, so both the clear pulse and its suppression can be observed.

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter #(
  parameter int                      N_SLOT     = 16,
  parameter int                      ADDR_W     = 16,
  parameter logic [ADDR_W-1:0]       VEC_BASE   = 16'hFFE0,
  parameter logic [2*N_SLOT-1:0]     CLASS_MAP  = 32'hA400_0000,
  parameter logic [N_SLOT-1:0]       SHARED_MAP = 16'h4004,
  localparam int                     SEL_W      = $clog2(N_SLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SLOT-1:0] flag_i,
  input  logic [N_SLOT-1:0] ie_i,
  input  logic              gie_i,
  input  logic              take_i,
  output logic              irq_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic [N_SLOT-1:0] clr_o
);

  localparam int TOP = N_SLOT - 1;

  logic [N_SLOT-1:0] elig;
  logic [SEL_W-1:0]  win;
  logic              hit;
  logic [N_SLOT-1:0] clr_q;

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    localparam logic [1:0] CLS = CLASS_MAP[2*i +: 2];
    if (i == TOP) begin : g_rst
      assign elig[i] = flag_i[i];
    end else if (CLS[1]) begin : g_nmi
      assign elig[i] = flag_i[i];
    end else if (CLS[0]) begin : g_part
      assign elig[i] = flag_i[i] & ie_i[i];
    end else begin : g_mask
      assign elig[i] = flag_i[i] & ie_i[i] & gie_i;
    end
  end

  always_comb begin
    win = '0;
    hit = 1'b0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (elig[i]) begin
        win = SEL_W'(i);
        hit = 1'b1;
      end
    end
  end

  assign irq_o    = hit;
  assign sel_o    = win;
  assign vector_o = hit ? VEC_BASE + (ADDR_W'(win) << 1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      clr_q <= '0;
    else if (take_i && hit && !SHARED_MAP[win] && (int'(win) != TOP))
      clr_q <= N_SLOT'(1) << win;
    else
      clr_q <= '0;
  end

  assign clr_o = clr_q;

endmodule

// File: rtl/irq_vector_arbiter_chk.sv
module irq_vector_arbiter_chk #(
  parameter int                  N_SLOT     = 16,
  parameter int                  ADDR_W     = 16,
  parameter logic [ADDR_W-1:0]   VEC_BASE   = 16'hFFE0,
  parameter logic [2*N_SLOT-1:0] CLASS_MAP  = 32'hA400_0000,
  parameter logic [N_SLOT-1:0]   SHARED_MAP = 16'h4004,
  localparam int                 SEL_W      = $clog2(N_SLOT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SLOT-1:0] flag_i,
  input logic [N_SLOT-1:0] ie_i,
  input logic              gie_i,
  input logic              take_i,
  input logic              irq_o,
  input logic [SEL_W-1:0]  sel_o,
  input logic [ADDR_W-1:0] vector_o,
  input logic [N_SLOT-1:0] clr_o
);
  localparam logic [SEL_W-1:0] TOP = SEL_W'(N_SLOT - 1);

  // R1
  a_r1_vector_addr: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vector_o == VEC_BASE + (ADDR_W'(sel_o) << 1)));
  // R2: the winner is a pending slot
  a_r2_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_i[sel_o]);
  // R4 and R5: enables respected for non-top, non-NMI slots
  a_r4_ie_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && sel_o != TOP && !CLASS_MAP[2*sel_o+1]) |-> ie_i[sel_o]);
  a_r5_gie_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !gie_i && sel_o != TOP) |-> (CLASS_MAP[2*sel_o +: 2] != 2'b00));
  // R6
  a_r6_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    flag_i[TOP] |-> (irq_o && sel_o == TOP));
  // R7
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (sel_o == '0 && vector_o == '0));
  // R8
  a_r8_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o));
  a_r8_clr_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |-> ($past(take_i) && $past(irq_o)));
  // R9
  a_r9_no_shared_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o & SHARED_MAP) == '0);
  a_r9_no_top_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_o[TOP]);
  // R10
  always_comb begin
    if (!rst_n) a_r10_reset_clear: assert (clr_o == '0);
  end
endmodule

bind irq_vector_arbiter irq_vector_arbiter_chk #(
  .N_SLOT(N_SLOT), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE),
  .CLASS_MAP(CLASS_MAP), .SHARED_MAP(SHARED_MAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .ie_i(ie_i), .gie_i(gie_i),
  .take_i(take_i), .irq_o(irq_o), .sel_o(sel_o), .vector_o(vector_o),
  .clr_o(clr_o)
);

// File: tb/tb_irq_vector_arbiter.sv
module tb_irq_vector_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] flag_i = '0;
  logic [15:0] ie_i = '0;
  logic        gie_i = 1'b0;
  logic        take_i = 1'b0;
  logic        irq_o;
  logic [3:0]  sel_o;
  logic [15:0] vector_o;
  logic [15:0] clr_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_vector_arbiter dut (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .ie_i(ie_i), .gie_i(gie_i),
    .take_i(take_i), .irq_o(irq_o), .sel_o(sel_o), .vector_o(vector_o),
    .clr_o(clr_o)
  );

  // fields: flag[37:22] ie[21:6] gie[5] irq[4] sel[3:0]
  localparam int NV = 13;
  localparam logic [37:0] TABLE [NV] = '{
    {16'h0000, 16'hFFFF, 1'b1, 1'b0, 4'd0},   // R7 nothing pending
    {16'h0001, 16'h0001, 1'b1, 1'b1, 4'd0},   // R1 R5 lowest slot
    {16'h0001, 16'h0001, 1'b0, 1'b0, 4'd0},   // R5 gie off
    {16'h0001, 16'h0000, 1'b1, 1'b0, 4'd0},   // R5 ie off
    {16'h2000, 16'h0000, 1'b1, 1'b0, 4'd0},   // R4 ie off
    {16'h2000, 16'h2000, 1'b0, 1'b1, 4'd13},  // R4 gie ignored
    {16'h4000, 16'h0000, 1'b0, 1'b1, 4'd14},  // R3
    {16'h8000, 16'h0000, 1'b0, 1'b1, 4'd15},  // R6
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 4'd15},  // R2 R6
    {16'h0128, 16'h0128, 1'b1, 1'b1, 4'd8},   // R2
    {16'h0128, 16'h0028, 1'b1, 1'b1, 4'd5},   // R2 R5
    {16'h2101, 16'h0101, 1'b0, 1'b0, 4'd0},   // R4 R5 all blocked
    {16'h6000, 16'h2000, 1'b0, 1'b1, 4'd14}   // R2 R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] f, input logic [15:0] e, input logic g);
    @(negedge clk);
    flag_i = f; ie_i = e; gie_i = g;
    #1;
  endtask

  task automatic take_and_check(input string req, input logic [15:0] exp);
    @(negedge clk);
    take_i = 1'b1;
    @(negedge clk);
    take_i = 1'b0;
    check(req, clr_o, exp);
    @(negedge clk);
    check(req, clr_o, 16'h0000);
  endtask

  initial begin
    #2;
    check("R10", clr_o, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", clr_o, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      logic [37:0] v;
      logic [15:0] xv;
      v = TABLE[k];
      apply(v[37:22], v[21:6], v[5]);
      xv = v[4] ? 16'hFFE0 + 16'(v[3:0]) * 16'd2 : 16'h0000;
      check("R2/R3/R4/R5/R6 irq", irq_o, v[4]);
      check("R2 sel", sel_o, v[3:0]);
      check("R1 vector", vector_o, xv);
    end

    apply(16'h8000, 16'h0000, 1'b0);
    check("R1 top vector", vector_o, 16'hFFFE);

    apply(16'h0020, 16'h0020, 1'b1);
    take_and_check("R8 single slot 5", 16'h0020);
    apply(16'h0001, 16'h0001, 1'b1);
    take_and_check("R8 single slot 0", 16'h0001);
    apply(16'h0004, 16'h0004, 1'b1);
    take_and_check("R9 shared slot 2", 16'h0000);
    apply(16'h4000, 16'h0000, 1'b0);
    take_and_check("R9 shared slot 14", 16'h0000);
    apply(16'h8000, 16'h0000, 1'b0);
    take_and_check("R9 top slot", 16'h0000);
    apply(16'h0020, 16'h0000, 1'b1);
    take_and_check("R9 no request", 16'h0000);

    apply(16'h0020, 16'h0020, 1'b1);
    @(negedge clk);
    take_i = 1'b1;
    #1 rst_n = 1'b0;
    #1 check("R10 reset during take", clr_o, 16'h0000);
    @(negedge clk);
    take_i = 1'b0;
    check("R10 held", clr_o, 16'h0000);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule